// File: doc/BRIEF.md
# Quad-Pumped Bus Inversion and Parity Codec

This block sits between a core and a 64-bit active-low data bus that carries four sub-phases of data in every bus clock. All four sub-phases of one clock are handled together as a single 256-bit word. On the send side it splits each sub-phase into four 16-bit lanes. For each lane it decides on its own whether sending the lane inverted would pull fewer wires low. It then drives the electrical data levels, one active-low inversion flag per lane and one even-parity bit per lane, which also covers that lane's flag.

On the receive side the block takes the electrical levels, the flags and the parity bits of one clock. It restores the logical data and checks parity for every lane. Any mismatch is folded into a sticky per-group error vector that the core clears explicitly. Each direction is one register stage with a plain valid qualifier. Strobe generation, analog capture and bus ownership are handled elsewhere.

Top module: `qp_dbi_codec`

## Requirements
- R1: Sub-phase k (0..3) occupies bits 64k+63:64k of every 256-bit word. Within a sub-phase, group g (0..3) is bits 16g+15:16g. The flag and parity bit for that lane sit at index 4k+g of the 16-bit flag and parity vectors.
- R2: A lane with 8 or fewer logical ones is sent uninverted. Its electrical levels are the bitwise complement of the logical data, since logical 1 is driven low, and its flag is driven high (1).
- R3: A lane with 9 or more logical ones is sent inverted. Its electrical levels equal the logical data and its flag is driven low (0).
- R4: A lane with exactly 8 logical ones is sent uninverted, with its flag high.
- R5: Every lane of every sub-phase is decided independently of all the other lanes.
- R6: Each transmitted parity bit makes the XOR of the lane's 16 electrical data bits, its flag level and the parity bit itself equal 0.
- R7: Transmit outputs appear one clock after tx_valid_i, with bus_valid_o high in that clock. When tx_valid_i is low, bus_data_o, bus_inv_n_o and bus_par_o keep their values and bus_valid_o is low in the next clock.
- R8: No lane of a valid transmitted word has more than 8 data wires at electrical low.
- R9: One clock after rx_valid_i, rx_valid_o is high and each lane of rx_data_o equals its electrical data XOR 16 copies of its flag level.
- R10: Bit g of rx_perr_o is set one clock after a valid received word in which any sub-phase has a parity mismatch in group g. The bit stays set until it is cleared.
- R11: rx_perr_clr_i clears rx_perr_o in the next clock. A mismatch arriving in the same clock as the clear sets its bit anyway.
- R12: During reset, bus_valid_o and rx_valid_o are 0, bus_data_o, bus_inv_n_o and bus_par_o are all ones, and rx_data_o and rx_perr_o are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_data_i | input | 256 | Logical data, four sub-phases |
| bus_valid_o | output | 1 | Encoded word valid |
| bus_data_o | output | 256 | Electrical data levels |
| bus_inv_n_o | output | 16 | Active-low inversion flags, one per lane |
| bus_par_o | output | 16 | Even parity per lane |
| rx_valid_i | input | 1 | Received word valid |
| rx_data_i | input | 256 | Received electrical data levels |
| rx_inv_n_i | input | 16 | Received inversion flags |
| rx_par_i | input | 16 | Received parity bits |
| rx_perr_clr_i | input | 1 | Clear sticky parity errors |
| rx_valid_o | output | 1 | Decoded word valid |
| rx_data_o | output | 256 | Restored logical data |
| rx_perr_o | output | 4 | Sticky parity error per group |

## Verification
A wrong inversion decision shows at the bus port in the clock after the word goes in. It appears as a lane with nine or more wires low, or as a flag that disagrees with the lane's logical weight, and a parity bit computed over the wrong levels shows in the same clock. On the receive side, a bad restore corrupts rx_data_o in the clock after rx_valid_i. A broken sticky register shows up at rx_perr_o either as a bit that drops while no clear is given or as a bit that survives a clear. The bench loops each transmitted word back through the decoder's ports, so a damaged error path also shows as a spurious error bit.

// File: rtl/qp_dbi_pkg.sv
package qp_dbi_pkg;
  parameter int unsigned DEF_GRP_W  = 16;
  parameter int unsigned DEF_GRPS   = 4;
  parameter int unsigned DEF_PHASES = 4;
endpackage

// File: rtl/dbi_grp_enc.sv
module dbi_grp_enc #(
  parameter int unsigned GRP_W = 16
) (
  input  logic [GRP_W-1:0] logic_i,
  output logic [GRP_W-1:0] elec_o,
  output logic             inv_n_o,
  output logic             par_o
);
  localparam int unsigned CNT_W = $clog2(GRP_W + 1);
  localparam int unsigned HALF  = GRP_W / 2;

  logic [CNT_W-1:0] ones;
  logic             heavy;
  logic [GRP_W-1:0] elec;

  always_comb begin
    ones = '0;
    for (int i = 0; i < GRP_W; i++) begin
      ones = ones + CNT_W'(logic_i[i]);
    end
  end

  assign heavy   = (ones > CNT_W'(HALF));
  assign elec    = heavy ? logic_i : ~logic_i;
  assign elec_o  = elec;
  assign inv_n_o = ~heavy;
  assign par_o   = ^{elec, ~heavy};
endmodule

// File: rtl/dbi_grp_dec.sv
module dbi_grp_dec #(
  parameter int unsigned GRP_W = 16
) (
  input  logic [GRP_W-1:0] elec_i,
  input  logic             inv_n_i,
  input  logic             par_i,
  output logic [GRP_W-1:0] logic_o,
  output logic             perr_o
);
  assign logic_o = elec_i ^ {GRP_W{inv_n_i}};
  assign perr_o  = ^{elec_i, inv_n_i, par_i};
endmodule

// File: rtl/qp_dbi_tx.sv
module qp_dbi_tx #(
  parameter int unsigned GRP_W  = 16,
  parameter int unsigned GRPS   = 4,
  parameter int unsigned PHASES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            valid_i,
  input  logic [GRP_W*GRPS*PHASES-1:0]    data_i,
  output logic                            valid_o,
  output logic [GRP_W*GRPS*PHASES-1:0]    data_o,
  output logic [GRPS*PHASES-1:0]          inv_n_o,
  output logic [GRPS*PHASES-1:0]          par_o
);
  localparam int unsigned LANES = GRPS * PHASES;
  localparam int unsigned W     = GRP_W * LANES;

  logic [W-1:0]     enc_data;
  logic [LANES-1:0] enc_inv_n;
  logic [LANES-1:0] enc_par;

  logic             valid_q, valid_d;
  logic [W-1:0]     data_q, data_d;
  logic [LANES-1:0] inv_n_q, inv_n_d;
  logic [LANES-1:0] par_q, par_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dbi_grp_enc #(.GRP_W(GRP_W)) u_enc (
      .logic_i (data_i[l*GRP_W +: GRP_W]),
      .elec_o  (enc_data[l*GRP_W +: GRP_W]),
      .inv_n_o (enc_inv_n[l]),
      .par_o   (enc_par[l])
    );
  end

  always_comb begin
    valid_d = valid_i;
    data_d  = data_q;
    inv_n_d = inv_n_q;
    par_d   = par_q;
    if (valid_i) begin
      data_d  = enc_data;
      inv_n_d = enc_inv_n;
      par_d   = enc_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '1;
      inv_n_q <= '1;
      par_q   <= '1;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      inv_n_q <= inv_n_d;
      par_q   <= par_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign inv_n_o = inv_n_q;
  assign par_o   = par_q;
endmodule

// File: rtl/qp_dbi_rx.sv
module qp_dbi_rx #(
  parameter int unsigned GRP_W  = 16,
  parameter int unsigned GRPS   = 4,
  parameter int unsigned PHASES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            valid_i,
  input  logic [GRP_W*GRPS*PHASES-1:0]    data_i,
  input  logic [GRPS*PHASES-1:0]          inv_n_i,
  input  logic [GRPS*PHASES-1:0]          par_i,
  input  logic                            clr_i,
  output logic                            valid_o,
  output logic [GRP_W*GRPS*PHASES-1:0]    data_o,
  output logic [GRPS-1:0]                 perr_o
);
  localparam int unsigned LANES = GRPS * PHASES;
  localparam int unsigned W     = GRP_W * LANES;

  logic [W-1:0]     dec_data;
  logic [LANES-1:0] lane_err;
  logic [GRPS-1:0]  grp_hit;

  logic             valid_q, valid_d;
  logic [W-1:0]     data_q, data_d;
  logic [GRPS-1:0]  perr_q, perr_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dbi_grp_dec #(.GRP_W(GRP_W)) u_dec (
      .elec_i  (data_i[l*GRP_W +: GRP_W]),
      .inv_n_i (inv_n_i[l]),
      .par_i   (par_i[l]),
      .logic_o (dec_data[l*GRP_W +: GRP_W]),
      .perr_o  (lane_err[l])
    );
  end

  always_comb begin
    grp_hit = '0;
    for (int k = 0; k < PHASES; k++) begin
      for (int g = 0; g < GRPS; g++) begin
        grp_hit[g] = grp_hit[g] | lane_err[k*GRPS + g];
      end
    end
  end

  always_comb begin
    valid_d = valid_i;
    data_d  = data_q;
    perr_d  = clr_i ? '0 : perr_q;
    if (valid_i) begin
      data_d = dec_data;
      perr_d = perr_d | grp_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign perr_o  = perr_q;
endmodule

// File: rtl/qp_dbi_codec.sv
module qp_dbi_codec
  import qp_dbi_pkg::*;
#(
  parameter int unsigned GRP_W  = DEF_GRP_W,
  parameter int unsigned GRPS   = DEF_GRPS,
  parameter int unsigned PHASES = DEF_PHASES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tx_valid_i,
  input  logic [GRP_W*GRPS*PHASES-1:0] tx_data_i,
  output logic                         bus_valid_o,
  output logic [GRP_W*GRPS*PHASES-1:0] bus_data_o,
  output logic [GRPS*PHASES-1:0]       bus_inv_n_o,
  output logic [GRPS*PHASES-1:0]       bus_par_o,
  input  logic                         rx_valid_i,
  input  logic [GRP_W*GRPS*PHASES-1:0] rx_data_i,
  input  logic [GRPS*PHASES-1:0]       rx_inv_n_i,
  input  logic [GRPS*PHASES-1:0]       rx_par_i,
  input  logic                         rx_perr_clr_i,
  output logic                         rx_valid_o,
  output logic [GRP_W*GRPS*PHASES-1:0] rx_data_o,
  output logic [GRPS-1:0]              rx_perr_o
);
  qp_dbi_tx #(.GRP_W(GRP_W), .GRPS(GRPS), .PHASES(PHASES)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (tx_valid_i),
    .data_i  (tx_data_i),
    .valid_o (bus_valid_o),
    .data_o  (bus_data_o),
    .inv_n_o (bus_inv_n_o),
    .par_o   (bus_par_o)
  );

  qp_dbi_rx #(.GRP_W(GRP_W), .GRPS(GRPS), .PHASES(PHASES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (rx_valid_i),
    .data_i  (rx_data_i),
    .inv_n_i (rx_inv_n_i),
    .par_i   (rx_par_i),
    .clr_i   (rx_perr_clr_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .perr_o  (rx_perr_o)
  );
endmodule

// File: rtl/qp_dbi_codec_chk.sv
module qp_dbi_codec_chk #(
  parameter int unsigned GRP_W  = 16,
  parameter int unsigned GRPS   = 4,
  parameter int unsigned PHASES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tx_valid_i,
  input logic                         bus_valid_o,
  input logic [GRP_W*GRPS*PHASES-1:0] bus_data_o,
  input logic [GRPS*PHASES-1:0]       bus_inv_n_o,
  input logic [GRPS*PHASES-1:0]       bus_par_o,
  input logic                         rx_valid_i,
  input logic                         rx_perr_clr_i,
  input logic                         rx_valid_o,
  input logic [GRPS-1:0]              rx_perr_o
);
  localparam int unsigned LANES = GRPS * PHASES;

  AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_i |=> bus_valid_o); // R7

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_i |=> ($stable(bus_data_o) && $stable(bus_inv_n_o) && $stable(bus_par_o) && !bus_valid_o)); // R7

  AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> rx_valid_o); // R9

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_perr_clr_i && !rx_valid_i) |=> (rx_perr_o == '0)); // R11

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_perr_o[g] && !rx_perr_clr_i) |=> rx_perr_o[g]); // R10
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o |-> ($countones(~bus_data_o[l*GRP_W +: GRP_W]) <= GRP_W/2)); // R8

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o |-> ((^{bus_data_o[l*GRP_W +: GRP_W], bus_inv_n_o[l], bus_par_o[l]}) == 1'b0)); // R6
  end
endmodule

bind qp_dbi_codec qp_dbi_codec_chk #(.GRP_W(GRP_W), .GRPS(GRPS), .PHASES(PHASES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_valid_i    (tx_valid_i),
  .bus_valid_o   (bus_valid_o),
  .bus_data_o    (bus_data_o),
  .bus_inv_n_o   (bus_inv_n_o),
  .bus_par_o     (bus_par_o),
  .rx_valid_i    (rx_valid_i),
  .rx_perr_clr_i (rx_perr_clr_i),
  .rx_valid_o    (rx_valid_o),
  .rx_perr_o     (rx_perr_o)
);

// File: tb/qp_dbi_codec_bench.sv
module qp_dbi_codec_bench;
  localparam int W     = 256;
  localparam int LANES = 16;
  localparam int BW    = W + 2*LANES;

  logic           clk;
  logic           rst_n;
  logic           tx_valid_i;
  logic [W-1:0]   tx_data_i;
  logic           bus_valid_o;
  logic [W-1:0]   bus_data_o;
  logic [15:0]    bus_inv_n_o;
  logic [15:0]    bus_par_o;
  logic           rx_valid_i;
  logic [W-1:0]   rx_data_i;
  logic [15:0]    rx_inv_n_i;
  logic [15:0]    rx_par_i;
  logic           rx_perr_clr_i;
  logic           rx_valid_o;
  logic [W-1:0]   rx_data_o;
  logic [3:0]     rx_perr_o;

  int n_checks;
  int n_fail;
  bit done;

  qp_dbi_codec u_qp_dbi_codec (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .bus_valid_o(bus_valid_o), .bus_data_o(bus_data_o),
    .bus_inv_n_o(bus_inv_n_o), .bus_par_o(bus_par_o),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_inv_n_i(rx_inv_n_i), .rx_par_i(rx_par_i),
    .rx_perr_clr_i(rx_perr_clr_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_perr_o(rx_perr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // packed as {parity, flags, data}
  function automatic logic [BW-1:0] enc_model(input logic [W-1:0] d);
    logic [W-1:0] e;
    logic [15:0]  f, p;
    for (int l = 0; l < LANES; l++) begin
      logic [15:0] g;
      g = d[l*16 +: 16];
      if ($countones(g) >= 9) begin
        e[l*16 +: 16] = g;
        f[l] = 1'b0;
      end else begin
        e[l*16 +: 16] = ~g;
        f[l] = 1'b1;
      end
      p[l] = ^{e[l*16 +: 16], f[l]};
    end
    return {p, f, e};
  endfunction

  function automatic logic [15:0] n_ones(input int n, input int rot);
    logic [15:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    for (int i = 0; i < rot; i++) v = {v[14:0], v[15]};
    return v;
  endfunction

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] d;
    for (int l = 0; l < LANES; l++) begin
      case ($urandom % 4)
        0: d[l*16 +: 16] = 16'($urandom);
        1: d[l*16 +: 16] = n_ones(8, $urandom % 16);
        2: d[l*16 +: 16] = n_ones(9, $urandom % 16);
        default: d[l*16 +: 16] = n_ones($urandom % 17, $urandom % 16);
      endcase
    end
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic tx_send(input logic [W-1:0] d, input string req);
    logic [BW-1:0] exp, act;
    @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = d;
    @(negedge clk);
    tx_valid_i = 1'b0;
    exp = enc_model(d);
    act = {bus_par_o, bus_inv_n_o, bus_data_o};
    chk(bus_valid_o && act == exp, req, act, exp);
  endtask

  task automatic rx_send(input logic [BW-1:0] bus, input logic clr,
                         input logic [W-1:0] exp_d, input logic [3:0] exp_e, input string req);
    @(negedge clk);
    rx_valid_i    = 1'b1;
    rx_par_i      = bus[BW-1 -: 16];
    rx_inv_n_i    = bus[W +: 16];
    rx_data_i     = bus[W-1:0];
    rx_perr_clr_i = clr;
    @(negedge clk);
    rx_valid_i    = 1'b0;
    rx_perr_clr_i = 1'b0;
    chk(rx_valid_o && rx_data_o == exp_d && rx_perr_o == exp_e, req,
        BW'({rx_perr_o, rx_data_o}), BW'({exp_e, exp_d}));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [W-1:0]  d, d2;
    logic [BW-1:0] b;
    int unsigned   seed;
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    seed = $urandom(32'd5150);
    rst_n = 1'b0;
    tx_valid_i = 1'b0; tx_data_i = '0;
    rx_valid_i = 1'b0; rx_data_i = '0; rx_inv_n_i = '1; rx_par_i = '0;
    rx_perr_clr_i = 1'b0;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk(!bus_valid_o && bus_data_o == '1 && bus_inv_n_o == '1 && bus_par_o == '1,
        "R12 tx reset", {bus_par_o, bus_inv_n_o, bus_data_o}, '1);
    chk(!rx_valid_o && rx_data_o == '0 && rx_perr_o == '0,
        "R12 rx reset", BW'({rx_perr_o, rx_data_o}), '0);
    rst_n = 1'b1;

    // R2 all zero: every lane uninverted, all wires high
    tx_send('0, "R2 all zero");
    // R3 all ones: every lane inverted
    tx_send('1, "R3 all ones");
    // R4 exactly 8 ones per lane
    for (int l = 0; l < LANES; l++) d[l*16 +: 16] = n_ones(8, l);
    tx_send(d, "R4 eight ones");
    // R3 nine ones per lane
    for (int l = 0; l < LANES; l++) d[l*16 +: 16] = n_ones(9, l);
    tx_send(d, "R3 nine ones");
    // R1 R5 single heavy lane: phase 2 group 1, lane 9
    d = '0;
    d[9*16 +: 16] = 16'hFFFF;
    tx_send(d, "R1 R5 single heavy lane");
    chk(bus_inv_n_o == 16'hFDFF, "R1 flag index", BW'(bus_inv_n_o), BW'(16'hFDFF));

    // R7 hold while not valid
    d = rand_word();
    tx_send(d, "R7 send");
    @(negedge clk);
    tx_valid_i = 1'b0;
    tx_data_i  = ~d;
    @(negedge clk);
    b = enc_model(d);
    chk(!bus_valid_o && {bus_par_o, bus_inv_n_o, bus_data_o} == b, "R7 hold",
        {bus_par_o, bus_inv_n_o, bus_data_o}, b);

    // R5 R6 random
    for (int i = 0; i < 200; i++) tx_send(rand_word(), "R5 R6 random encode");

    // R9 loopback decode with no errors
    for (int i = 0; i < 200; i++) begin
      d = rand_word();
      rx_send(enc_model(d), 1'b0, d, 4'b0000, "R9 loopback");
    end

    // R10 injected mismatch in phase 2 group 1 (lane 9)
    d = rand_word();
    b = enc_model(d);
    b[9*16 + 3] = ~b[9*16 + 3];
    d2 = d;
    d2[9*16 + 3] = ~d2[9*16 + 3];
    rx_send(b, 1'b0, d2, 4'b0010, "R10 set group1");
    d = rand_word();
    rx_send(enc_model(d), 1'b0, d, 4'b0010, "R10 sticky");

    // R11 clear while idle
    @(negedge clk);
    rx_perr_clr_i = 1'b1;
    @(negedge clk);
    rx_perr_clr_i = 1'b0;
    chk(rx_perr_o == 4'b0000, "R11 clear", BW'(rx_perr_o), '0);

    // R10 parity bit flip in phase 0 group 0 sets group 0
    d = rand_word();
    b = enc_model(d);
    b[W+16+0] = ~b[W+16+0];
    rx_send(b, 1'b0, d, 4'b0001, "R10 parity bit flip");

    // R11 clear with simultaneous error in group 3 (phase 3, lane 15 flag)
    d = rand_word();
    b = enc_model(d);
    b[W+15] = ~b[W+15];
    d2 = d;
    d2[15*16 +: 16] = ~d2[15*16 +: 16];
    rx_send(b, 1'b1, d2, 4'b1000, "R11 clear vs set");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule